// File: doc/BRIEF.md
# Strobed Watchdog Timer Register

This block is a watchdog counter stepped by a 32 Hz tick enable and driven through one 8-bit control register. Software stores a six-bit timeout multiplier in the register. The counter then counts down that many ticks. If the counter runs out before software strobes it, the block raises a sticky timeout flag and starts a new interval. A timeout of N gives N × 31.25 ms, from one tick up to 63 ticks (about 2 s). A stored value of zero turns the watchdog off.

Bit 7 of the register is a strobe. Writing 1 to it asks for a reload, and it always reads back as 0. Bit 6 is a protect bit. While it is set, writes leave the timeout field alone, so software can strobe without rewriting the interval. The counter takes up a new timeout value, and acts on a strobe, only at the next tick after the write. Reading the register clears the flag.

Top module: `wdt_top`

## Requirements
- R1: One cycle after a read request, the read data shows `{1'b0, protect, timeout[5:0]}`, meaning the strobe is bit 7 and always reads 0, protect is bit 6, and the timeout is bits 5:0. The read data holds its value between reads.
- R2: Reset, active low, clears the stored timeout, the protect bit, the counter, the pending-reload state, the flag and the read data.
- R3: While the stored timeout is 0, the counter is disabled and the flag is never set.
- R4: A write with bit 7 = 1 schedules a reload from the stored timeout at the next tick. A write with bit 7 = 0 and protect already set does not touch the counter.
- R5: If protect was 1 before a write, that write leaves the timeout field unchanged. The protect bit takes the written bit 6 on every write.
- R6: A timeout written while protect is 0 appears in the readback at once. It is loaded into the counter only at the next tick, and that tick does not count down.
- R7: Once the counter is loaded with N ≥ 1, the flag sets on the Nth following tick, and the counter reloads from the stored timeout at that same tick.
- R8: The flag stays set until a read request. If an expiry and a read happen in the same cycle, the flag ends up set.
- R9: When a write and a tick happen in the same cycle, the tick acts on the state from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick32 | input | 1 | 32 Hz tick enable, one cycle wide |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Write data: strobe[7], protect[6], timeout[5:0] |
| rdEn | input | 1 | Register read request; also clears the flag |
| rdData | output | 8 | Registered read data |
| timeoutFlag | output | 1 | Sticky expiry flag |

## Verification
The counter itself has no readback. A wrong count, a missed reload or a stray pending state therefore shows up only as the flag rising one or more ticks early or late. It can take up to 63 ticks after the fault before the flag reveals it. A corrupted timeout or protect register shows up on the first read that follows, one cycle after the read request. The stimulus is arranged so that each ordering fault moves the flag edge by at least one tick: early load at write time, a strobe that is ignored, a protect bit taken after the write, or a tick that sees post-write state.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // Strobes from the control to the datapath, all valid for one cycle.
  typedef struct packed {
    logic writeTmo;   // take the timeout field from the write data
    logic writeMask;  // take the protect bit from the write data
    logic reload;     // load the counter from the stored timeout (pending reload)
    logic decrement;  // count down by one
    logic setFlag;    // expiry: set the flag and reload the counter
    logic clearFlag;  // read request: clear the flag
    logic capture;    // latch the read data
  } wdtCtl_t;
endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int TMO_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             wrEn,
  input  logic             wrStrobe,
  input  logic             rdEn,
  input  logic             maskQ,
  input  logic [TMO_W-1:0] tmoQ,
  input  logic [TMO_W-1:0] countQ,
  output wdtCtl_t          ctl
);
  localparam logic [TMO_W-1:0] ONE = TMO_W'(1);

  logic pendQ;
  logic enabled;
  logic armReq;

  assign enabled = (tmoQ != '0);
  // A strobe, or a timeout write that protect allows, asks for a reload at the next tick.
  assign armReq  = wrEn & (wrStrobe | ~maskQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendQ <= 1'b0;
    else       pendQ <= armReq | (pendQ & ~tick);
  end

  always_comb begin
    ctl           = '0;
    ctl.writeTmo  = wrEn & ~maskQ;
    ctl.writeMask = wrEn;
    ctl.reload    = tick & pendQ;
    ctl.decrement = tick & ~pendQ & enabled & (countQ != ONE);
    ctl.setFlag   = tick & ~pendQ & enabled & (countQ == ONE);
    ctl.clearFlag = rdEn;
    ctl.capture   = rdEn;
  end

  // R6: pending reload state is consumed only by a tick
  assert_pending_drops_on_tick_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pendQ) |-> $past(tick));

  // R4: a strobe write always leaves a reload pending
  assert_strobe_arms_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrStrobe) |=> pendQ);
endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int TMO_W = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  wdtCtl_t            ctl,
  input  logic [TMO_W-1:0]   wrField,
  input  logic               wrMask,
  output logic [TMO_W-1:0]   tmoQ,
  output logic               maskQ,
  output logic [TMO_W-1:0]   countQ,
  output logic               flagQ,
  output logic [TMO_W+1:0]   rdData
);
  localparam int DATA_W = TMO_W + 2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmoQ  <= '0;
      maskQ <= 1'b0;
    end else begin
      if (ctl.writeTmo)  tmoQ  <= wrField;
      if (ctl.writeMask) maskQ <= wrMask;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         countQ <= '0;
    else if (ctl.reload | ctl.setFlag) countQ <= tmoQ;
    else if (ctl.decrement)            countQ <= countQ - 1'b1;
  end

  // The flag sets in preference to clearing, so an expiry is never lost.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              flagQ <= 1'b0;
    else if (ctl.setFlag)   flagQ <= 1'b1;
    else if (ctl.clearFlag) flagQ <= 1'b0;
  end

  // The strobe bit has no storage, so bit DATA_W-1 reads 0.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rdData <= '0;
    else if (ctl.capture) rdData <= {1'b0, maskQ, tmoQ};
  end

  // R3: the flag only rises while a nonzero timeout is stored
  assert_flag_needs_timeout_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagQ) |-> ($past(tmoQ) != '0));

  // R7: after a reload or an expiry, the counter holds the pre-edge timeout
  assert_reload_value_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ctl.reload) || $past(ctl.setFlag)) |-> (countQ == $past(tmoQ)));

  // R1: the top bit of the read data never reads 1
  assert_strobe_reads_low_R1: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctl.capture) |-> (rdData[DATA_W-1] == 1'b0));
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int TMO_W = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tick32,
  input  logic               wrEn,
  input  logic [TMO_W+1:0]   wrData,
  input  logic               rdEn,
  output logic [TMO_W+1:0]   rdData,
  output logic               timeoutFlag
);
  localparam int DATA_W   = TMO_W + 2;
  localparam int STB_BIT  = DATA_W - 1;
  localparam int MASK_BIT = DATA_W - 2;

  wdtCtl_t          ctl;
  logic [TMO_W-1:0] tmoQ;
  logic [TMO_W-1:0] countQ;
  logic             maskQ;

  wdt_ctrl #(.TMO_W(TMO_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick32), .wrEn(wrEn),
    .wrStrobe(wrData[STB_BIT]), .rdEn(rdEn), .maskQ(maskQ),
    .tmoQ(tmoQ), .countQ(countQ), .ctl(ctl)
  );

  wdt_datapath #(.TMO_W(TMO_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .wrField(wrData[TMO_W-1:0]), .wrMask(wrData[MASK_BIT]),
    .tmoQ(tmoQ), .maskQ(maskQ), .countQ(countQ),
    .flagQ(timeoutFlag), .rdData(rdData)
  );

  // R5: a write with protect already set leaves the timeout field unchanged
  assert_mask_protects_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && maskQ) |=> (tmoQ == $past(tmoQ)));

  // R5: the protect bit follows every write
  assert_mask_follows_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (maskQ == $past(wrData[MASK_BIT])));

  // R9: the counter moves only on a tick
  assert_count_only_on_tick_R9: assert property (@(posedge clk) disable iff (!rstN)
    !tick32 |=> $stable(countQ));

  // R8: the flag stays set until a read request
  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (timeoutFlag && !rdEn) |=> timeoutFlag);
endmodule

// File: tb/sim_wdt_top.sv
module sim_wdt_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 43;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick32 = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic       rdEn = 1'b0;
  logic [7:0] rdData;
  logic       timeoutFlag;

  int nChecks = 0;
  int nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_top u0 (
    .clk(clk), .rstN(rstN), .tick32(tick32), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .timeoutFlag(timeoutFlag)
  );

  // Vector fields: {wr, wdata[8], rd, tick, expFlag, expRd[8], req[4]}
  // Expected values are the outputs at the negedge after the applying posedge.
  localparam logic [23:0] VEC [NVEC] = '{
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00, 4'd1}, //  1 R1 read after reset
    {1'b1, 8'h03, 1'b0, 1'b0, 1'b0, 8'h00, 4'd1}, //  2 R1 write tmo=3, read data held
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h03, 4'd6}, //  3 R6 readback shows new tmo at once
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h03, 4'd6}, //  4 R6 load tick, no count
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h03, 4'd7}, //  5 R7
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h03, 4'd7}, //  6 R7
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 8'h03, 4'd7}, //  7 R7 third tick expires
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h03, 4'd8}, //  8 R8 read clears flag
    {1'b1, 8'h43, 1'b0, 1'b0, 1'b0, 8'h03, 4'd5}, //  9 R5 set protect, tmo written (old protect 0)
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h03, 4'd6}, // 10 R6 load
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h03, 4'd7}, // 11 R7 count 2
    {1'b1, 8'hC5, 1'b0, 1'b0, 1'b0, 8'h03, 4'd4}, // 12 R4 strobe, protected field
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h03, 4'd4}, // 13 R4 reload to 3
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h03, 4'd4}, // 14 R4 no expiry yet
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h03, 4'd4}, // 15 R4
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 8'h03, 4'd4}, // 16 R4 expiry after reload
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h43, 4'd5}, // 17 R5 tmo kept at 3, strobe reads 0
    {1'b1, 8'h41, 1'b0, 1'b0, 1'b0, 8'h43, 4'd4}, // 18 R4 strobe 0 under protect: no reload
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h43, 4'd4}, // 19 R4 count 2
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h43, 4'd4}, // 20 R4 count 1
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 8'h43, 4'd4}, // 21 R4 expiry on 3rd tick
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h43, 4'd5}, // 22 R5 tmo still 3
    {1'b1, 8'h01, 1'b0, 1'b0, 1'b0, 8'h43, 4'd5}, // 23 R5 clear protect, field ignored
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h03, 4'd5}, // 24 R5 protect 0, tmo 3
    {1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 8'h03, 4'd3}, // 25 R3 tmo=0
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h03, 4'd3}, // 26 R3 load 0
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h03, 4'd3}, // 27 R3 disabled
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h03, 4'd3}, // 28 R3 disabled
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00, 4'd3}, // 29 R3 read tmo 0
    {1'b1, 8'h02, 1'b0, 1'b0, 1'b0, 8'h00, 4'd6}, // 30 R6 tmo=2
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00, 4'd6}, // 31 R6 load tick
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00, 4'd6}, // 32 R6 count 1
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 8'h00, 4'd6}, // 33 R6 expire
    {1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 8'h02, 4'd8}, // 34 R8 read clears, tick counts
    {1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 8'h02, 4'd8}, // 35 R8 expiry beats read
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h02, 4'd8}, // 36 R8 read clears
    {1'b1, 8'h84, 1'b0, 1'b1, 1'b0, 8'h02, 4'd9}, // 37 R9 write+tick: tick counts 2->1
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h02, 4'd9}, // 38 R9 pending load of 4, no expiry
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h02, 4'd9}, // 39 R9
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h02, 4'd9}, // 40 R9
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h02, 4'd9}, // 41 R9
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 8'h02, 4'd9}, // 42 R9 expiry 4 ticks after load
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h04, 4'd1}  // 43 R1 readback 4
  };

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive at a negedge, let one posedge act, sample at the following negedge.
  task automatic step(input logic w, input logic [7:0] d, input logic r, input logic t);
    wrEn = w; wrData = d; rdEn = r; tick32 = t;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0; rdEn = 1'b0; tick32 = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFails++;
    nChecks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R2 reset flag", timeoutFlag, 0);
    check("R2 reset rdData", rdData, 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      logic [23:0] v;
      v = VEC[i];
      step(v[23], v[22:15], v[14], v[13]);
      check($sformatf("R%0d vec%0d flag", v[3:0], i + 1), timeoutFlag, v[12]);
      check($sformatf("R%0d vec%0d rdData", v[3:0], i + 1), rdData, v[11:4]);
    end

    // R7: largest timeout, 63 ticks after load
    step(1'b0, 8'h00, 1'b1, 1'b0);
    step(1'b1, 8'h3F, 1'b0, 1'b0);
    step(1'b0, 8'h00, 1'b0, 1'b1);
    for (int k = 1; k <= 62; k++) step(1'b0, 8'h00, 1'b0, 1'b1);
    check("R7 max tmo no early flag", timeoutFlag, 0);
    step(1'b0, 8'h00, 1'b0, 1'b1);
    check("R7 max tmo flag at 63", timeoutFlag, 1);

    // R7: smallest timeout, one tick
    step(1'b0, 8'h00, 1'b1, 1'b0);
    step(1'b1, 8'h01, 1'b0, 1'b0);
    step(1'b0, 8'h00, 1'b0, 1'b1);
    check("R7 tmo1 load tick", timeoutFlag, 0);
    step(1'b0, 8'h00, 1'b0, 1'b1);
    check("R7 tmo1 expiry", timeoutFlag, 1);

    // R2: reset in the middle of operation
    step(1'b1, 8'h45, 1'b0, 1'b0);
    rstN = 1'b0;
    @(negedge clk);
    check("R2 mid reset flag", timeoutFlag, 0);
    check("R2 mid reset rdData", rdData, 0);
    rstN = 1'b1;
    @(negedge clk);
    step(1'b0, 8'h00, 1'b1, 1'b0);
    check("R2 regs cleared", rdData, 8'h00);
    for (int k = 0; k < 4; k++) step(1'b0, 8'h00, 1'b0, 1'b1);
    check("R2 R3 disabled after reset", timeoutFlag, 0);
    // R5: protect was cleared by reset, so this field write lands
    step(1'b1, 8'h07, 1'b0, 1'b0);
    step(1'b0, 8'h00, 1'b1, 1'b0);
    check("R2 R5 protect cleared by reset", rdData, 8'h07);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule